// File: doc/BRIEF.md
# Coherent Two-Way Data Cache Controller

This block is the data-side cache controller for one processor core. It holds 8 KB of data as 128 sets of two 32-byte lines and keeps each line in one of four coherence states: Modified (dirty), Exclusive (clean and held only here), Shared (other caches may also hold it) and Invalid (not present). The core issues word loads and stores. Hits are served from the local tag, state and data arrays. Misses, write-through traffic and dirty evictions go out over a simple request/acknowledge memory port that moves either one whole line or one word.

An external agent can probe any address. A probe either downgrades the matching line to Shared or invalidates it, and a dirty line is written back before the probe completes. Two level inputs shape CPU traffic. `cacheOff` sends every access straight to memory and allocates nothing. `writeBackEn` selects write-back stores; when it is low, stores use write-through. A flush request walks the whole array, writes back every dirty line and leaves all lines Invalid.

Top module: `mesi_dcache`

## Requirements
- R1: After reset every line is Invalid, so the first load of any address misses. `memReq`, `cpuDone`, `probeDone` and `flushDone` are low.
- R2: While `cacheOff` is 1, each CPU load or store makes exactly one single-word memory access (`memLine`=0) and allocates no line. A later load with `cacheOff`=0 to the same line therefore misses.
- R3: A load miss reads the line with one line transfer (`memLine`=1) and returns the addressed word. The line is filled Exclusive if `memShared` is 0 and Shared if it is 1. A load hit returns the word with no bus traffic. The refill uses an Invalid way first (way 0 before way 1), otherwise the least recently used way.
- R4: With `writeBackEn`=1, a store hit on an Exclusive or Modified line leaves the line Modified with no bus traffic. A store hit on a Shared line makes one single-word memory write and leaves the line Exclusive.
- R5: With `writeBackEn`=0, every store hit writes the word to memory and updates the cached copy. The line state does not change.
- R6: A store miss makes one single-word memory write and allocates no line.
- R7: If the way chosen for a refill holds a Modified line, that line is first written back with one line write to its own address.
- R8: A read probe (`probeInv`=0) that hits reports `probeHit`=1 and leaves the line Shared. If the line is Modified, one line write-back happens first.
- R9: An invalidating probe (`probeInv`=1) that hits leaves the line Invalid, with a write-back first only if the line is Modified. A probe that misses reports `probeHit`=0 and makes no bus access.
- R10: A flush writes back every Modified line in ascending set order, way 0 before way 1 within a set. It then leaves all lines Invalid and raises `flushDone` for exactly one cycle.
- R11: When requests are pending together in the idle state, a probe is served before a flush, and a flush before a CPU access. At most one of `cpuDone`, `probeDone` and `flushDone` is high in any cycle.
- R12: Once raised, `memReq` stays high with `memAddr` and `memWrite` unchanged until the cycle in which `memAck` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cacheOff | input | 1 | 1: bypass the cache for CPU accesses |
| writeBackEn | input | 1 | 1: write-back stores, 0: write-through stores |
| cpuReq | input | 1 | CPU request, held until `cpuDone` |
| cpuWe | input | 1 | 1 store, 0 load |
| cpuAddr | input | 32 | CPU byte address (word aligned) |
| cpuWData | input | 32 | Store data |
| cpuRData | output | 32 | Load data, valid with `cpuDone` |
| cpuDone | output | 1 | One-cycle completion of a CPU access |
| probeReq | input | 1 | External probe request, held until `probeDone` |
| probeInv | input | 1 | 1 invalidating probe, 0 read probe |
| probeAddr | input | 32 | Probe byte address |
| probeHit | output | 1 | Probe found the line, valid with `probeDone` |
| probeDone | output | 1 | One-cycle completion of a probe |
| flushReq | input | 1 | Flush request, held until `flushDone` |
| flushDone | output | 1 | One-cycle flush completion |
| memReq | output | 1 | Memory request |
| memWrite | output | 1 | 1 write, 0 read |
| memLine | output | 1 | 1 whole-line transfer, 0 single word in bits 31:0 |
| memAddr | output | 32 | Byte address (line aligned when `memLine`=1) |
| memWData | output | 256 | Write data |
| memRData | input | 256 | Read data, valid with `memAck` |
| memAck | input | 1 | One-cycle completion of the memory request |
| memShared | input | 1 | Another cache holds the line being read |

## Verification
Two functions can become ready in the same cycle: a CPU load and an invalidating probe aimed at the same Modified line. The bench raises both requests on the same clock edge. It then checks three things: the probe completes first, exactly one line write-back precedes a fresh line read, and the load returns the value stored before the probe. That value must come back from memory, so it shows that the probe's write-back and invalidation both happened before the CPU access was looked up.

// File: rtl/mesi_dc_pkg.sv
package mesi_dc_pkg;

  typedef enum logic [1:0] {
    M_INV = 2'd0,
    M_SHR = 2'd1,
    M_EXC = 2'd2,
    M_MOD = 2'd3
  } mesi_t;

  typedef enum logic [1:0] {
    OP_CPU = 2'd0,
    OP_PRB = 2'd1,
    OP_FLS = 2'd2
  } dcOp_t;

  typedef struct packed {
    logic  wrWord;
    logic  fill;
    logic  setState;
    mesi_t newState;
    logic  touch;
  } dpStrobe_t;

endpackage

// File: rtl/mesi_dc_dpath.sv
module mesi_dc_dpath
  import mesi_dc_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LINE_WORDS = 8,
  parameter int SETS = 128,
  parameter int TAG_W = 20,
  localparam int LINE_W = WORD_W * LINE_WORDS,
  localparam int IDX_W = $clog2(SETS),
  localparam int WSEL_W = $clog2(LINE_WORDS),
  localparam int NUM_WAYS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [IDX_W-1:0]  idx,
  input  logic [TAG_W-1:0]  tag,
  input  logic [WSEL_W-1:0] wordSel,
  input  logic              selWay,
  input  logic [WORD_W-1:0] wrData,
  input  logic [LINE_W-1:0] fillData,
  output logic              hit,
  output logic              hitWay,
  output logic              victimWay,
  output mesi_t             selState,
  output logic [LINE_W-1:0] selLine,
  output logic [TAG_W-1:0]  selTag
);

  mesi_t [NUM_WAYS-1:0] wayState;
  logic  [NUM_WAYS-1:0][TAG_W-1:0]  wayTag;
  logic  [NUM_WAYS-1:0][LINE_W-1:0] wayLine;
  logic  [NUM_WAYS-1:0] hitVec;
  logic  [SETS-1:0] lruBit;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    mesi_t             stArr   [SETS];
    logic [TAG_W-1:0]  tagArr  [SETS];
    logic [LINE_W-1:0] dataArr [SETS];
    logic              wayPick;

    assign wayPick     = (selWay == w[0]);
    assign wayState[w] = stArr[idx];
    assign wayTag[w]   = tagArr[idx];
    assign wayLine[w]  = dataArr[idx];
    assign hitVec[w]   = (stArr[idx] != M_INV) && (tagArr[idx] == tag);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int s = 0; s < SETS; s++) stArr[s] <= M_INV;
      end else if (strb.setState && wayPick) begin
        stArr[idx] <= strb.newState;
      end
    end

    always_ff @(posedge clk) begin
      if (strb.fill && wayPick) begin
        tagArr[idx]  <= tag;
        dataArr[idx] <= fillData;
      end else if (strb.wrWord && wayPick) begin
        dataArr[idx][wordSel*WORD_W +: WORD_W] <= wrData;
      end
    end
  end

  assign hit    = |hitVec;
  assign hitWay = hitVec[1];

  always_comb begin
    if (wayState[0] == M_INV)      victimWay = 1'b0;
    else if (wayState[1] == M_INV) victimWay = 1'b1;
    else                           victimWay = lruBit[idx];
  end

  assign selState = wayState[selWay];
  assign selLine  = wayLine[selWay];
  assign selTag   = wayTag[selWay];

  // lruBit holds the way to replace next: the one not used most recently
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           lruBit <= '0;
    else if (strb.touch) lruBit[idx] <= ~selWay;
  end

  // R4: a word is only ever merged into a line that is present
  a_r4_write_valid_line: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrWord |-> selState != M_INV);

endmodule

// File: rtl/mesi_dc_ctrl.sv
module mesi_dc_ctrl
  import mesi_dc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int LINE_WORDS = 8,
  parameter int SETS = 128,
  localparam int LINE_W = WORD_W * LINE_WORDS,
  localparam int IDX_W = $clog2(SETS),
  localparam int WSEL_W = $clog2(LINE_WORDS),
  localparam int BOFF_W = $clog2(WORD_W / 8),
  localparam int OFF_W = WSEL_W + BOFF_W,
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cacheOff,
  input  logic              writeBackEn,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [WORD_W-1:0] cpuWData,
  output logic [WORD_W-1:0] cpuRData,
  output logic              cpuDone,
  input  logic              probeReq,
  input  logic              probeInv,
  input  logic [ADDR_W-1:0] probeAddr,
  output logic              probeHit,
  output logic              probeDone,
  input  logic              flushReq,
  output logic              flushDone,
  output logic              memReq,
  output logic              memWrite,
  output logic              memLine,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LINE_W-1:0] memWData,
  input  logic [LINE_W-1:0] memRData,
  input  logic              memAck,
  input  logic              memShared,
  output dpStrobe_t         strb,
  output logic [IDX_W-1:0]  dpIdx,
  output logic [TAG_W-1:0]  dpTag,
  output logic [WSEL_W-1:0] dpWord,
  output logic              dpSelWay,
  output logic [WORD_W-1:0] dpWrData,
  output logic [LINE_W-1:0] dpFillData,
  input  logic              hit,
  input  logic              hitWay,
  input  logic              victimWay,
  input  mesi_t             selState,
  input  logic [LINE_W-1:0] selLine,
  input  logic [TAG_W-1:0]  selTag
);

  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_WB, S_FILL, S_SINGLE, S_FLUSH
  } cState_t;

  cState_t           st;
  dcOp_t             op;
  logic [ADDR_W-1:0] addrReg;
  logic [WORD_W-1:0] wdReg;
  logic              weReg, invReg, offReg, wbReg, curWay;
  logic [IDX_W-1:0]  flushSet;
  logic              lookWay, flushLast, shrStoreHit;

  assign lookWay   = hit ? hitWay : victimWay;
  assign dpSelWay  = (st == S_LOOK) ? lookWay : curWay;
  assign dpIdx     = (op == OP_FLS) ? flushSet : addrReg[OFF_W +: IDX_W];
  assign dpTag     = addrReg[ADDR_W-1 -: TAG_W];
  assign dpWord    = addrReg[BOFF_W +: WSEL_W];
  assign dpWrData  = wdReg;
  assign dpFillData = memRData;
  assign flushLast = curWay && (flushSet == IDX_W'(SETS - 1));
  // store hit on a Shared line in write-back mode: written through once
  assign shrStoreHit = hit && (selState == M_SHR) && wbReg && !offReg;

  // strobes towards the datapath
  always_comb begin
    strb = '0;
    strb.newState = M_INV;
    case (st)
      S_LOOK: begin
        if (op == OP_CPU && !offReg && hit) begin
          strb.touch  = 1'b1;
          strb.wrWord = weReg;
          if (weReg && wbReg && selState == M_EXC) begin
            strb.setState = 1'b1;
            strb.newState = M_MOD;
          end
        end else if (op == OP_PRB && hit && selState != M_MOD) begin
          strb.setState = 1'b1;
          strb.newState = invReg ? M_INV : M_SHR;
        end
      end
      S_WB: if (memAck && op != OP_CPU) begin
        strb.setState = 1'b1;
        strb.newState = (op == OP_PRB && !invReg) ? M_SHR : M_INV;
      end
      S_FILL: if (memAck) begin
        strb.fill     = 1'b1;
        strb.touch    = 1'b1;
        strb.setState = 1'b1;
        strb.newState = memShared ? M_SHR : M_EXC;
      end
      S_SINGLE: if (memAck && op == OP_CPU && weReg && shrStoreHit) begin
        strb.setState = 1'b1;
        strb.newState = M_EXC;
      end
      S_FLUSH: if (selState != M_MOD) begin
        strb.setState = 1'b1;
        strb.newState = M_INV;
      end
      default: ;
    endcase
  end

  // sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= S_IDLE; op <= OP_CPU;
      addrReg <= '0; wdReg <= '0;
      weReg <= 1'b0; invReg <= 1'b0; offReg <= 1'b0; wbReg <= 1'b0;
      curWay <= 1'b0; flushSet <= '0;
      cpuRData <= '0; cpuDone <= 1'b0;
      probeHit <= 1'b0; probeDone <= 1'b0; flushDone <= 1'b0;
    end else begin
      cpuDone   <= 1'b0;
      probeDone <= 1'b0;
      flushDone <= 1'b0;
      case (st)
        S_IDLE: begin
          if (probeReq) begin
            op <= OP_PRB; addrReg <= probeAddr; invReg <= probeInv;
            st <= S_LOOK;
          end else if (flushReq) begin
            op <= OP_FLS; flushSet <= '0; curWay <= 1'b0;
            st <= S_FLUSH;
          end else if (cpuReq) begin
            op <= OP_CPU; addrReg <= cpuAddr; wdReg <= cpuWData;
            weReg <= cpuWe; offReg <= cacheOff; wbReg <= writeBackEn;
            st <= S_LOOK;
          end
        end
        S_LOOK: begin
          curWay <= lookWay;
          if (op == OP_PRB) begin
            probeHit <= hit;
            if (hit && selState == M_MOD) st <= S_WB;
            else begin
              probeDone <= 1'b1;
              st <= S_IDLE;
            end
          end else if (offReg) begin
            st <= S_SINGLE;
          end else if (hit) begin
            if (!weReg) begin
              cpuRData <= selLine[dpWord*WORD_W +: WORD_W];
              cpuDone  <= 1'b1;
              st <= S_IDLE;
            end else if (!wbReg || selState == M_SHR) begin
              st <= S_SINGLE;
            end else begin
              cpuDone <= 1'b1;
              st <= S_IDLE;
            end
          end else if (weReg) begin
            st <= S_SINGLE;
          end else if (selState == M_MOD) begin
            st <= S_WB;
          end else begin
            st <= S_FILL;
          end
        end
        S_WB: if (memAck) begin
          case (op)
            OP_CPU: st <= S_FILL;
            OP_PRB: begin
              probeDone <= 1'b1;
              st <= S_IDLE;
            end
            default: begin
              if (flushLast) begin
                flushDone <= 1'b1;
                st <= S_IDLE;
              end else begin
                if (curWay) flushSet <= flushSet + 1'b1;
                curWay <= ~curWay;
                st <= S_FLUSH;
              end
            end
          endcase
        end
        S_FILL: if (memAck) begin
          cpuRData <= memRData[dpWord*WORD_W +: WORD_W];
          cpuDone  <= 1'b1;
          st <= S_IDLE;
        end
        S_SINGLE: if (memAck) begin
          if (!weReg) cpuRData <= memRData[WORD_W-1:0];
          cpuDone <= 1'b1;
          st <= S_IDLE;
        end
        S_FLUSH: begin
          if (selState == M_MOD) begin
            st <= S_WB;
          end else if (flushLast) begin
            flushDone <= 1'b1;
            st <= S_IDLE;
          end else begin
            if (curWay) flushSet <= flushSet + 1'b1;
            curWay <= ~curWay;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // memory port, driven from registered state only
  always_comb begin
    memReq   = (st == S_WB) || (st == S_FILL) || (st == S_SINGLE);
    memWrite = (st == S_WB) || (st == S_SINGLE && weReg);
    memLine  = (st != S_SINGLE);
    memWData = '0;
    case (st)
      S_WB:     begin
        memAddr  = {selTag, dpIdx, {OFF_W{1'b0}}};
        memWData = selLine;
      end
      S_FILL:   memAddr = {addrReg[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      S_SINGLE: begin
        memAddr  = addrReg;
        memWData = {{(LINE_W-WORD_W){1'b0}}, wdReg};
      end
      default:  memAddr = '0;
    endcase
  end

  // R11: completions never overlap
  a_r11_one_done: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cpuDone, probeDone, flushDone}));

  // R12: request held steady until acknowledged
  a_r12_bus_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWrite));

  // R2: no line read while the access was taken in bypass mode
  a_r2_no_fill_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memLine && !memWrite) |-> !offReg);

  // R10: flush completion lasts a single cycle
  a_r10_flush_pulse: assert property (@(posedge clk) disable iff (!rstN)
    flushDone |=> !flushDone);

  // R9: a probe that misses causes no memory request
  a_r9_probe_miss_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_LOOK && op == OP_PRB && !hit) |=> !memReq);

endmodule

// File: rtl/mesi_dcache.sv
module mesi_dcache
  import mesi_dc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int LINE_WORDS = 8,
  parameter int SETS = 128,
  localparam int LINE_W = WORD_W * LINE_WORDS,
  localparam int IDX_W = $clog2(SETS),
  localparam int WSEL_W = $clog2(LINE_WORDS),
  localparam int OFF_W = WSEL_W + $clog2(WORD_W / 8),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cacheOff,
  input  logic              writeBackEn,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [WORD_W-1:0] cpuWData,
  output logic [WORD_W-1:0] cpuRData,
  output logic              cpuDone,
  input  logic              probeReq,
  input  logic              probeInv,
  input  logic [ADDR_W-1:0] probeAddr,
  output logic              probeHit,
  output logic              probeDone,
  input  logic              flushReq,
  output logic              flushDone,
  output logic              memReq,
  output logic              memWrite,
  output logic              memLine,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LINE_W-1:0] memWData,
  input  logic [LINE_W-1:0] memRData,
  input  logic              memAck,
  input  logic              memShared
);

  dpStrobe_t         strb;
  logic [IDX_W-1:0]  dpIdx;
  logic [TAG_W-1:0]  dpTag;
  logic [WSEL_W-1:0] dpWord;
  logic              dpSelWay, hit, hitWay, victimWay;
  logic [WORD_W-1:0] dpWrData;
  logic [LINE_W-1:0] dpFillData, selLine;
  logic [TAG_W-1:0]  selTag;
  mesi_t             selState;

  mesi_dc_ctrl #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS), .SETS(SETS)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .cacheOff(cacheOff), .writeBackEn(writeBackEn),
    .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWData(cpuWData),
    .cpuRData(cpuRData), .cpuDone(cpuDone),
    .probeReq(probeReq), .probeInv(probeInv), .probeAddr(probeAddr),
    .probeHit(probeHit), .probeDone(probeDone),
    .flushReq(flushReq), .flushDone(flushDone),
    .memReq(memReq), .memWrite(memWrite), .memLine(memLine), .memAddr(memAddr),
    .memWData(memWData), .memRData(memRData), .memAck(memAck),
    .memShared(memShared),
    .strb(strb), .dpIdx(dpIdx), .dpTag(dpTag), .dpWord(dpWord),
    .dpSelWay(dpSelWay), .dpWrData(dpWrData), .dpFillData(dpFillData),
    .hit(hit), .hitWay(hitWay), .victimWay(victimWay), .selState(selState),
    .selLine(selLine), .selTag(selTag)
  );

  mesi_dc_dpath #(
    .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS), .SETS(SETS), .TAG_W(TAG_W)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .idx(dpIdx), .tag(dpTag),
    .wordSel(dpWord), .selWay(dpSelWay), .wrData(dpWrData),
    .fillData(dpFillData), .hit(hit), .hitWay(hitWay), .victimWay(victimWay),
    .selState(selState), .selLine(selLine), .selTag(selTag)
  );

endmodule

// File: tb/test_mesi_dcache.sv
module test_mesi_dcache;

  logic clk = 1'b0, rstN = 1'b0;
  logic cacheOff = 1'b0, writeBackEn = 1'b1;
  logic cpuReq = 1'b0, cpuWe = 1'b0;
  logic [31:0] cpuAddr = '0, cpuWData = '0, cpuRData;
  logic cpuDone;
  logic probeReq = 1'b0, probeInv = 1'b0;
  logic [31:0] probeAddr = '0;
  logic probeHit, probeDone;
  logic flushReq = 1'b0, flushDone;
  logic memReq, memWrite, memLine;
  logic [31:0] memAddr;
  logic [255:0] memWData;
  logic [255:0] memRData = '0;
  logic memAck = 1'b0, memShared = 1'b0;

  always #5 clk = ~clk;

  mesi_dcache i_mesi_dcache (
    .clk(clk), .rstN(rstN), .cacheOff(cacheOff), .writeBackEn(writeBackEn),
    .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWData(cpuWData),
    .cpuRData(cpuRData), .cpuDone(cpuDone),
    .probeReq(probeReq), .probeInv(probeInv), .probeAddr(probeAddr),
    .probeHit(probeHit), .probeDone(probeDone),
    .flushReq(flushReq), .flushDone(flushDone),
    .memReq(memReq), .memWrite(memWrite), .memLine(memLine), .memAddr(memAddr),
    .memWData(memWData), .memRData(memRData), .memAck(memAck),
    .memShared(memShared)
  );

  int nChecks = 0, nErrors = 0;
  int nFill = 0, nLineWr = 0, nWordWr = 0, nWordRd = 0, holdBad = 0;
  logic [31:0] memArr [logic [31:0]];
  logic [31:0] truth  [logic [31:0]];
  logic [31:0] lineWrQ [$];
  time tCpu, tProbe;

  typedef struct { bit isRead; logic [31:0] data; string req; } expItem_t;
  expItem_t expQ [$];

  function automatic logic [31:0] initWord(logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [31:0] memRd(logic [31:0] a);
    return memArr.exists(a) ? memArr[a] : initWord(a);
  endfunction

  function automatic logic [31:0] addrOf(int tg, int set, int word);
    return {tg[19:0], set[6:0], word[2:0], 2'b00};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  endtask

  // memory model: two-cycle latency, one-cycle acknowledge, hold checking (R12)
  int lat = 0;
  bit holdPend = 1'b0, hWr;
  logic [31:0] hAddr;
  always @(negedge clk) begin
    if (!rstN) begin
      memAck = 1'b0; lat = 0;
    end else if (memAck) begin
      memAck = 1'b0;
    end else if (memReq) begin
      lat++;
      if (lat >= 2) begin
        logic [31:0] base;
        lat = 0;
        memAck = 1'b1;
        base = memLine ? {memAddr[31:5], 5'b0} : {memAddr[31:2], 2'b0};
        if (memWrite && memLine) begin
          for (int i = 0; i < 8; i++) memArr[base + 32'(4*i)] = memWData[32*i +: 32];
          lineWrQ.push_back(base);
          nLineWr++;
        end else if (memWrite) begin
          memArr[base] = memWData[31:0];
          nWordWr++;
        end else if (memLine) begin
          for (int i = 0; i < 8; i++) memRData[32*i +: 32] = memRd(base + 32'(4*i));
          nFill++;
        end else begin
          memRData = {224'b0, memRd(base)};
          nWordRd++;
        end
      end
    end
    if (rstN && holdPend && !(memReq && memAddr == hAddr && memWrite == hWr)) holdBad++;
    holdPend = rstN && memReq && !memAck;
    hAddr = memAddr;
    hWr = memWrite;
  end

  // scoreboard monitor and flush pulse watcher
  bit prevFlushDone = 1'b0;
  always @(negedge clk) begin
    if (rstN && cpuDone) begin
      if (expQ.size() == 0) check(1'b0, "R11 unexpected cpuDone", 32'd1, 32'd0);
      else begin
        expItem_t e;
        e = expQ.pop_front();
        if (e.isRead) check(cpuRData == e.data, e.req, cpuRData, e.data);
      end
    end
    if (rstN && prevFlushDone && flushDone)
      check(1'b0, "R10 flushDone longer than one cycle", 32'd1, 32'd0);
    prevFlushDone = flushDone;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      check(1'b0, "watchdog expired", 32'(cyc), 32'd100000);
      finishRun();
    end
  end

  task automatic cpuAcc(bit we, logic [31:0] a, logic [31:0] d, string req);
    expItem_t e;
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = a; cpuWData = d;
    if (we) truth[a] = d;
    e.isRead = !we;
    e.data = truth.exists(a) ? truth[a] : initWord(a);
    e.req = req;
    expQ.push_back(e);
    do @(negedge clk); while (!cpuDone);
    cpuReq = 1'b0;
    tCpu = $time;
  endtask

  task automatic probe(logic [31:0] a, bit inv, bit expHit, string req);
    @(negedge clk);
    probeReq = 1'b1; probeInv = inv; probeAddr = a;
    do @(negedge clk); while (!probeDone);
    check(probeHit == expHit, req, 32'(probeHit), 32'(expHit));
    probeReq = 1'b0;
    tProbe = $time;
  endtask

  task automatic flushAll();
    @(negedge clk);
    flushReq = 1'b1;
    do @(negedge clk); while (!flushDone);
    flushReq = 1'b0;
  endtask

  initial begin
    logic [31:0] a, b, c, d, e, x1, x2, y;
    int f0, w0, l0, r0;
    a = addrOf(1, 5, 2); b = addrOf(2, 5, 3); c = addrOf(3, 5, 0);
    d = addrOf(4, 9, 1); e = addrOf(6, 20, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: outputs quiet after reset
    check(!memReq && !cpuDone && !probeDone && !flushDone, "R1 reset outputs",
          {28'b0, memReq, cpuDone, probeDone, flushDone}, 32'd0);

    // R1/R3: first load misses and fills Exclusive
    f0 = nFill;
    cpuAcc(1'b0, a, '0, "R3 read miss data");
    check(nFill == f0 + 1, "R1 first load misses", 32'(nFill - f0), 32'd1);
    cpuAcc(1'b0, a, '0, "R3 read hit data");
    check(nFill == f0 + 1, "R3 hit has no bus traffic", 32'(nFill - f0), 32'd1);

    // R4: Exclusive store hit becomes Modified silently
    w0 = nWordWr; l0 = nLineWr;
    cpuAcc(1'b1, a, 32'h1111_0001, "R4");
    check(nWordWr == w0 && nLineWr == l0, "R4 E store silent", 32'(nWordWr - w0), 32'd0);

    // R3/R4: shared fill into way 1, first store writes through once
    memShared = 1'b1;
    cpuAcc(1'b0, b, '0, "R3 shared fill data");
    memShared = 1'b0;
    w0 = nWordWr;
    cpuAcc(1'b1, b, 32'h2222_0002, "R4");
    check(nWordWr == w0 + 1, "R4 S store writes once", 32'(nWordWr - w0), 32'd1);
    check(memRd(b) == 32'h2222_0002, "R4 S store word in memory", memRd(b), 32'h2222_0002);
    cpuAcc(1'b1, b, 32'h2222_0003, "R4");
    check(nWordWr == w0 + 1, "R4 second store silent", 32'(nWordWr - w0), 32'd1);

    // R7/R3: least recently used way (A, Modified) is evicted
    l0 = nLineWr; f0 = nFill;
    cpuAcc(1'b0, c, '0, "R7 refill data");
    check(nLineWr == l0 + 1, "R7 dirty victim written back", 32'(nLineWr - l0), 32'd1);
    check(memRd(a) == 32'h1111_0001, "R7 victim data in memory", memRd(a), 32'h1111_0001);
    check(nFill == f0 + 1, "R3 refill after eviction", 32'(nFill - f0), 32'd1);

    // R5: write-through store hit
    writeBackEn = 1'b0;
    w0 = nWordWr;
    cpuAcc(1'b1, c, 32'h3333_0004, "R5");
    check(nWordWr == w0 + 1, "R5 write-through store", 32'(nWordWr - w0), 32'd1);
    check(memRd(c) == 32'h3333_0004, "R5 memory updated", memRd(c), 32'h3333_0004);
    cpuAcc(1'b0, c, '0, "R5 cached copy updated");
    writeBackEn = 1'b1;

    // R6: store miss, no allocation
    w0 = nWordWr; f0 = nFill;
    cpuAcc(1'b1, d, 32'h4444_0005, "R6");
    check(nWordWr == w0 + 1 && nFill == f0, "R6 store miss single write",
          32'(nWordWr - w0), 32'd1);
    cpuAcc(1'b0, d, '0, "R6 read after store miss");
    check(nFill == f0 + 1, "R6 no line allocated", 32'(nFill - f0), 32'd1);

    // R2: bypass mode
    cacheOff = 1'b1;
    r0 = nWordRd; f0 = nFill; w0 = nWordWr;
    cpuAcc(1'b0, e, '0, "R2 bypass read data");
    check(nWordRd == r0 + 1 && nFill == f0, "R2 bypass read single word",
          32'(nWordRd - r0), 32'd1);
    cpuAcc(1'b1, e, 32'h5555_0006, "R2");
    check(nWordWr == w0 + 1, "R2 bypass write single word", 32'(nWordWr - w0), 32'd1);
    cacheOff = 1'b0;
    cpuAcc(1'b0, e, '0, "R2 read after bypass");
    check(nFill == f0 + 1, "R2 bypass allocated nothing", 32'(nFill - f0), 32'd1);

    // R8: read probe on Modified B
    l0 = nLineWr;
    probe(b, 1'b0, 1'b1, "R8 probe hit");
    check(nLineWr == l0 + 1, "R8 modified line written back", 32'(nLineWr - l0), 32'd1);
    check(memRd(b) == 32'h2222_0003, "R8 write-back data", memRd(b), 32'h2222_0003);
    w0 = nWordWr;
    cpuAcc(1'b1, b, 32'h2222_0006, "R8");
    check(nWordWr == w0 + 1, "R8 line left Shared", 32'(nWordWr - w0), 32'd1);

    // R9: probe miss and invalidate of a clean line
    l0 = nLineWr; r0 = nWordRd; f0 = nFill;
    probe(addrOf(7, 30, 0), 1'b1, 1'b0, "R9 probe miss");
    check(nLineWr == l0 && nWordRd == r0 && nFill == f0, "R9 probe miss quiet",
          32'(nLineWr - l0), 32'd0);
    probe(c, 1'b1, 1'b1, "R9 invalidate hit");
    check(nLineWr == l0, "R9 clean line not written", 32'(nLineWr - l0), 32'd0);
    cpuAcc(1'b0, c, '0, "R9 refetch data");
    check(nFill == f0 + 1, "R9 line invalidated", 32'(nFill - f0), 32'd1);

    // R11: probe and CPU load on the same dirty line in the same cycle
    cpuAcc(1'b1, b, 32'h2222_0007, "R11");
    l0 = nLineWr; f0 = nFill;
    fork
      cpuAcc(1'b0, b, '0, "R11 load after probe");
      probe(b, 1'b1, 1'b1, "R11 probe hit");
    join
    check(tProbe < tCpu, "R11 probe served first", 32'(tProbe), 32'(tCpu));
    check(nLineWr == l0 + 1 && nFill == f0 + 1, "R11 write-back then refill",
          32'(nLineWr - l0), 32'd1);

    // R10: flush order
    flushAll();
    x1 = addrOf(8, 3, 0); x2 = addrOf(9, 3, 1); y = addrOf(10, 10, 2);
    cpuAcc(1'b0, x1, '0, "R10 setup");
    cpuAcc(1'b0, x2, '0, "R10 setup");
    cpuAcc(1'b0, y, '0, "R10 setup");
    cpuAcc(1'b1, x2, 32'h0000_0077, "R10");
    cpuAcc(1'b1, x1, 32'h0000_0066, "R10");
    cpuAcc(1'b1, y, 32'h0000_0088, "R10");
    lineWrQ.delete();
    flushAll();
    check(lineWrQ.size() == 3, "R10 write-back count", 32'(lineWrQ.size()), 32'd3);
    if (lineWrQ.size() == 3) begin
      check(lineWrQ[0] == {x1[31:5], 5'b0}, "R10 order set3 way0", lineWrQ[0], {x1[31:5], 5'b0});
      check(lineWrQ[1] == {x2[31:5], 5'b0}, "R10 order set3 way1", lineWrQ[1], {x2[31:5], 5'b0});
      check(lineWrQ[2] == {y[31:5], 5'b0}, "R10 order set10", lineWrQ[2], {y[31:5], 5'b0});
    end
    f0 = nFill;
    cpuAcc(1'b0, x1, '0, "R10 data after flush");
    check(nFill == f0 + 1, "R10 all lines invalid", 32'(nFill - f0), 32'd1);

    repeat (4) @(negedge clk);
    check(holdBad == 0, "R12 request held until acknowledge", 32'(holdBad), 32'd0);
    check(expQ.size() == 0, "R11 scoreboard drained", 32'(expQ.size()), 32'd0);
    finishRun();
  end

endmodule